// File: doc/BRIEF.md
# Dual-Channel PWM Counter Slice

This block is one slice of a pulse-width modulator. A single counter is shared by two compare channels. Each channel turns its compare value into a pulse train. Counting is paced by an external per-cycle count enable, so the slice runs at whatever rate the surrounding logic sets.

The slice has two counting modes. In edge-aligned mode the counter climbs from 0 to the wrap value and falls back to 0. In centre-aligned mode it climbs to the wrap value and then descends to 0, so every pulse sits in the middle of its period. Each channel has an invert flag that is applied after the compare.

The wrap value, the two compare values and the mode are held in shadow registers. New values take effect only at the start of a period or while the slice is disabled, so a reprogram in the middle of a period never produces a runt pulse.

The controller has three named states:

- `SL_IDLE`: the slice is disabled.
- `SL_UP`: the counter is counting upward.
- `SL_DOWN`: the counter is counting downward (centre-aligned mode only).

Transitions:

- `SL_IDLE` goes to `SL_UP` when the slice enable rises.
- `SL_UP` goes to `SL_DOWN` at the wrap value in centre-aligned mode.
- `SL_DOWN` goes to `SL_UP` at zero.
- Any state goes to `SL_IDLE` when the slice enable is low.

Top module: `pwm_slice`

## Requirements
- R1: While running, a channel output before inversion is 1 when its active compare value is greater than the counter value (unsigned), and 0 otherwise.
- R2: An active compare value of 0 keeps the non-inverted channel output at 0 for the whole period.
- R3: An active compare value equal to the active wrap value plus one keeps the non-inverted channel output at 1 for the whole period.
- R4: In edge-aligned mode (`phase_mode` = 0), each enabled count step adds one, and a step taken at the wrap value returns the counter to 0. The period is therefore wrap+1 steps.
- R5: In centre-aligned mode (`phase_mode` = 1), the counter climbs 0..wrap and then descends wrap..0. The value at each end is held for one extra step while the direction turns, so the period is 2·(wrap+1) steps.
- R6: Each channel's invert flag takes effect immediately and inverts only that channel's compare result.
- R7: While `slice_en` is low, the controller is in `SL_IDLE`: both outputs are 0 regardless of the invert flags, and the counter is 0. After reset and after re-enabling, counting starts from 0 upward.
- R8: The counter changes only in cycles where `cnt_en` is 1.
- R9: The wrap value, compare values and mode are captured into the shadow registers only in two cases: while disabled, or on the step that starts a new period. In edge-aligned mode that step is the return to 0. In centre-aligned mode it is the turn at 0. Changes at any other time wait for the next period start.
- R10: `cnt_value` presents the current counter value, which never exceeds the active wrap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_en | input | 1 | Slice enable; low forces `SL_IDLE` |
| cnt_en | input | 1 | Per-cycle count enable |
| phase_mode | input | 1 | 0 = edge-aligned, 1 = centre-aligned (shadowed) |
| top_in | input | CNT_W | Wrap value (shadowed) |
| cmp_a_in | input | CNT_W | Channel A compare value (shadowed) |
| cmp_b_in | input | CNT_W | Channel B compare value (shadowed) |
| inv_a | input | 1 | Channel A output invert |
| inv_b | input | 1 | Channel B output invert |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |
| cnt_value | output | CNT_W | Current counter value |

## Verification
The bench builds the slice with the default 16-bit counter and two channels. It programs small wrap values (0, 2, 3, 4, 5, 7 and 9), so that several full periods in both modes fit into a few dozen steps.

A wrap value of 0 brings the degenerate one-value period within reach in both modes. A compare of wrap+1 reaches the fully-high end of the compare range.

Reprogramming while the counter sits above the new wrap value shows that the old period completes before the shadow registers update.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_UP   = 2'd1,
        SL_DOWN = 2'd2
    } slice_state_e;

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= d_in;
        end
    end

    assign q_out = hold_q;

endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slice_en,
    input  logic             cnt_en,
    input  logic             centre_act,
    input  logic [CNT_W-1:0] top_act,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running,
    output logic             reload
);

    slice_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_top;
    logic             at_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign at_top  = (cnt_q == top_act);
    assign at_zero = (cnt_q == '0);

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        reload  = 1'b0;
        unique case (state_q)
            SL_IDLE: begin
                reload = 1'b1;
                cnt_d  = '0;
                if (slice_en) begin
                    state_d = SL_UP;
                end
            end
            SL_UP: begin
                if (!slice_en) begin
                    state_d = SL_IDLE;
                    cnt_d   = '0;
                    reload  = 1'b1;
                end else if (cnt_en) begin
                    if (at_top) begin
                        if (centre_act) begin
                            state_d = SL_DOWN;
                        end else begin
                            cnt_d  = '0;
                            reload = 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SL_DOWN: begin
                if (!slice_en) begin
                    state_d = SL_IDLE;
                    cnt_d   = '0;
                    reload  = 1'b1;
                end else if (cnt_en) begin
                    if (at_zero) begin
                        state_d = SL_UP;
                        reload  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = SL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign running = (state_q != SL_IDLE);

endmodule

// File: rtl/pwm_compare_ch.sv
module pwm_compare_ch #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             invert,
    output logic             pwm
);

    logic above;

    assign above = (cmp_act > cnt);

    always_comb begin
        if (running) begin
            pwm = above ^ invert;
        end else begin
            pwm = 1'b0;
        end
    end

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slice_en,
    input  logic             cnt_en,
    input  logic             phase_mode,
    input  logic [CNT_W-1:0] top_in,
    input  logic [CNT_W-1:0] cmp_a_in,
    input  logic [CNT_W-1:0] cmp_b_in,
    input  logic             inv_a,
    input  logic             inv_b,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic [CNT_W-1:0] cnt_value
);

    localparam int NCH = 2;

    logic                      reload;
    logic                      running;
    logic                      centre_act;
    logic [CNT_W-1:0]          top_act;
    logic [CNT_W-1:0]          cnt_q;
    logic [NCH-1:0][CNT_W-1:0] cmp_in_all;
    logic [NCH-1:0][CNT_W-1:0] cmp_act_all;
    logic [NCH-1:0]            inv_all;
    logic [NCH-1:0]            pwm_all;
    logic [CNT_W-1:0]          cmp_a_act;
    logic [CNT_W-1:0]          cmp_b_act;

    assign cmp_in_all = {cmp_b_in, cmp_a_in};
    assign inv_all    = {inv_b, inv_a};

    pwm_shadow_reg #(.W(CNT_W)) u_top_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reload),
        .d_in  (top_in),
        .q_out (top_act)
    );

    pwm_shadow_reg #(.W(1)) u_mode_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reload),
        .d_in  (phase_mode),
        .q_out (centre_act)
    );

    pwm_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slice_en   (slice_en),
        .cnt_en     (cnt_en),
        .centre_act (centre_act),
        .top_act    (top_act),
        .cnt_q      (cnt_q),
        .running    (running),
        .reload     (reload)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        pwm_shadow_reg #(.W(CNT_W)) u_cmp_sh (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (reload),
            .d_in  (cmp_in_all[gi]),
            .q_out (cmp_act_all[gi])
        );

        pwm_compare_ch #(.CNT_W(CNT_W)) u_cmp (
            .running (running),
            .cnt     (cnt_q),
            .cmp_act (cmp_act_all[gi]),
            .invert  (inv_all[gi]),
            .pwm     (pwm_all[gi])
        );
    end

    assign cmp_a_act = cmp_act_all[0];
    assign cmp_b_act = cmp_act_all[1];

    // outputs
    always_comb begin
        pwm_a     = pwm_all[0];
        pwm_b     = pwm_all[1];
        cnt_value = cnt_q;
    end

endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slice_en,
    input logic             cnt_en,
    input logic             running,
    input logic             inv_a,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic [CNT_W-1:0] cnt_value,
    input logic [CNT_W-1:0] top_act,
    input logic [CNT_W-1:0] cmp_a_act
);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_en |=> (cnt_value == '0) && !pwm_a && !pwm_b);

    p_hold_no_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_value) || (cnt_value == '0));

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_en && cnt_en) |=>
            (cnt_value == $past(cnt_value)) ||
            (cnt_value == CNT_W'($past(cnt_value) + 1'b1)) ||
            (cnt_value == CNT_W'($past(cnt_value) - 1'b1)) ||
            (cnt_value == '0));

    p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_value <= top_act);

    p_full_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_a_act == '0) && !inv_a) |-> !pwm_a);

    p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !inv_a && ({1'b0, cmp_a_act} == ({1'b0, top_act} + 1'b1))) |-> pwm_a);

endmodule

bind pwm_slice pwm_slice_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slice_en  (slice_en),
    .cnt_en    (cnt_en),
    .running   (running),
    .inv_a     (inv_a),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .cnt_value (cnt_value),
    .top_act   (top_act),
    .cmp_a_act (cmp_a_act)
);

// File: tb/pwm_slice_tb_top.sv
module pwm_slice_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slice_en = 1'b0;
    logic             cnt_en = 1'b0;
    logic             phase_mode = 1'b0;
    logic [CNT_W-1:0] top_in = '0;
    logic [CNT_W-1:0] cmp_a_in = '0;
    logic [CNT_W-1:0] cmp_b_in = '0;
    logic             inv_a = 1'b0;
    logic             inv_b = 1'b0;
    logic             pwm_a;
    logic             pwm_b;
    logic [CNT_W-1:0] cnt_value;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    pwm_slice #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slice_en   (slice_en),
        .cnt_en     (cnt_en),
        .phase_mode (phase_mode),
        .top_in     (top_in),
        .cmp_a_in   (cmp_a_in),
        .cmp_b_in   (cmp_b_in),
        .inv_a      (inv_a),
        .inv_b      (inv_b),
        .pwm_a      (pwm_a),
        .pwm_b      (pwm_b),
        .cnt_value  (cnt_value)
    );

    function automatic int exp_cnt(int top, bit ph, int k);
        int p;
        if (!ph) return k % (top + 1);
        p = k % (2 * (top + 1));
        return (p <= top) ? p : (2 * top + 1 - p);
    endfunction

    task automatic check_state(string tag, int ec, bit ea, bit eb);
        n_tests++;
        if (cnt_value !== CNT_W'(ec) || pwm_a !== ea || pwm_b !== eb) begin
            n_fail++;
            $display("FAIL %s: cnt=%0d exp %0d, a=%0b exp %0b, b=%0b exp %0b",
                     tag, cnt_value, ec, pwm_a, ea, pwm_b, eb);
        end
    endtask

    task automatic configure(int top, int ca, int cb, bit ia, bit ib, bit ph);
        @(negedge clk);
        slice_en   = 1'b0;
        cnt_en     = 1'b0;
        top_in     = CNT_W'(top);
        cmp_a_in   = CNT_W'(ca);
        cmp_b_in   = CNT_W'(cb);
        inv_a      = ia;
        inv_b      = ib;
        phase_mode = ph;
        @(negedge clk);
        slice_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic step();
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic run_seq(int top, int ca, int cb, bit ia, bit ib, bit ph,
                           int n, string tag);
        int c;
        configure(top, ca, cb, ia, ib, ph);
        for (int k = 0; k <= n; k++) begin
            if (k > 0) step();
            c = exp_cnt(top, ph, k);
            check_state(tag, c, bit'((ca > c) ^ ia), bit'((cb > c) ^ ib));
        end
    endtask

    // R7 R10: state after reset
    task automatic t_reset();
        check_state("R7 reset", 0, 1'b0, 1'b0);
    endtask

    task automatic t_normal();
        run_seq(4, 2, 5, 1'b0, 1'b0, 1'b0, 12, "R1 R3 R4 R10 edge");
        run_seq(0, 1, 0, 1'b0, 1'b0, 1'b0, 4, "R4 top0 edge");
    endtask

    task automatic t_low_inv();
        run_seq(5, 0, 3, 1'b0, 1'b1, 1'b0, 14, "R2 R6 invert");
    endtask

    task automatic t_phase();
        run_seq(3, 2, 4, 1'b0, 1'b0, 1'b1, 18, "R5 R1 centre");
        run_seq(0, 1, 0, 1'b0, 1'b0, 1'b1, 5, "R5 top0 centre");
    endtask

    task automatic t_hold();
        configure(9, 5, 0, 1'b0, 1'b0, 1'b0);
        repeat (3) step();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check_state("R8 hold", 3, 1'b1, 1'b0);
        end
    endtask

    task automatic t_disable();
        configure(9, 4, 4, 1'b1, 1'b0, 1'b0);
        repeat (3) step();
        check_state("R6 inv running", 3, 1'b0, 1'b1);
        slice_en = 1'b0;
        cnt_en   = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_state("R7 disabled", 0, 1'b0, 1'b0);
        end
        slice_en = 1'b1;
        cnt_en   = 1'b0;
        @(negedge clk);
        check_state("R7 re-enable", 0, 1'b0, 1'b1);
        step();
        check_state("R7 first step", 1, 1'b0, 1'b1);
    endtask

    task automatic t_shadow();
        configure(7, 2, 0, 1'b0, 1'b0, 1'b0);
        repeat (3) step();
        check_state("R9 before change", 3, 1'b0, 1'b0);
        cmp_a_in = CNT_W'(6);
        top_in   = CNT_W'(2);
        step();
        check_state("R9 old compare kept", 4, 1'b0, 1'b0);
        repeat (3) step();
        check_state("R9 old wrap kept", 7, 1'b0, 1'b0);
        step();
        check_state("R9 wrap loads", 0, 1'b1, 1'b0);
        repeat (2) step();
        check_state("R9 new compare", 2, 1'b1, 1'b0);
        step();
        check_state("R9 new wrap", 0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_low_inv();
        t_phase();
        t_hold();
        t_disable();
        t_shadow();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule